// File: doc/BRIEF.md
# Flash Protection and OTP Controller

This block is the access gate of a 16 Mbit serial flash built from 32 blocks of 64 KB. A command decoder upstream hands it one decoded command per cycle with a 24-bit address and a data byte. The controller then decides whether a program or erase may go ahead. It answers each program, block erase or chip erase with a registered response one cycle later. The response carries a grant flag and a target flag that steers the write either to the main array or to a 64-byte one-time-programmable region.

The controller keeps five pieces of state:

- A write-enable latch. Every write-type command consumes it.
- A mode flag that selects the OTP region in place of the array.
- A 4-bit block-protect code. It maps to a region at the top of the array, a region at the bottom of the array, or the whole array.
- A customer lock bit that only ever sets.
- A view of a factory lock that comes from a fuse.

There are two resets. A warm reset clears only the mode flag and the latch. A power-on reset also returns the protect code and the customer lock to the blank-device state.

Top module: `fpc_access_ctrl`

## Requirements
- R1: After the warm reset `rst_n` is released, `otp_mode`, `wel` and `resp_valid` read 0, and `bp_code` and `sec_status[1]` keep their earlier values. After the power-on reset `por_n`, `bp_code` also reads 0 and `sec_status[1]` also reads 0.
- R2: Command op 0 sets `wel`. A program, a block erase, a chip erase, a security write or a protect write clears `wel`, whether the command is granted or denied and whether or not it has an effect. No grant is ever given while `wel` is 0.
- R3: Protect codes 1 to 5 guard the top 1, 2, 4, 8 and 16 blocks respectively. For example, code 1 guards only block 31 and code 5 guards blocks 16 to 31.
- R4: Protect codes 10 to 14 guard the bottom 16, 24, 28, 30 and 31 blocks respectively, counting up from block 0.
- R5: Code 0 guards no block. Codes 6, 7, 8, 9 and 15 guard all 32 blocks.
- R6: In array mode, a program (op 1) or a block erase (op 2) takes its block index from address bits [20:16] and is denied when that block is guarded. Address bits [23:21] have no effect. A chip erase (op 7) is denied when the protect code is not 0.
- R7: Op 3 sets `otp_mode` and op 4 clears it. While `otp_mode` is 1, a program is answered with `resp_otp`=1, and a block erase or a chip erase is denied. While `otp_mode` is 0, `resp_otp` is 0.
- R8: In OTP mode a program uses address bits [5:0] as the offset. Offsets 0x00 to 0x0F are denied while `factory_lock` is 1. Offsets 0x10 to 0x3F are denied while the customer lock is 1. The protect code has no effect in OTP mode.
- R9: `sec_status[0]` mirrors `factory_lock` and `sec_status[1]` is the customer lock. A security write (op 5) with `wel` set sets the customer lock when `cmd_data[1]` is 1. No command clears the customer lock, and `cmd_data[0]` and the other data bits have no effect.
- R10: A protect write (op 6) loads `cmd_data[3:0]` into `bp_code` only when `wel` is 1. Without `wel`, the protect code is unchanged.
- R11: `resp_valid` pulses for exactly one cycle, in the cycle after a program, block erase or chip erase is accepted. Ops 0, 3, 4, 5 and 6 produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Warm reset, asynchronous and active-low; clears the mode flag and the latch |
| por_n | input | 1 | Power-on reset, asynchronous and active-low; clears all state |
| factory_lock | input | 1 | Fuse value that locks the factory serial-number area |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 3 | Command code: 0 write enable, 1 program, 2 block erase, 3 enter OTP, 4 exit OTP, 5 security write, 6 protect write, 7 chip erase |
| cmd_addr | input | 24 | Byte address of the command |
| cmd_data | input | 8 | Data byte for the security write and the protect write |
| resp_valid | output | 1 | Response strobe for a program or an erase |
| resp_grant | output | 1 | 1 when the operation may proceed |
| resp_otp | output | 1 | 1 when the operation targets the OTP region |
| wel | output | 1 | Write-enable latch |
| otp_mode | output | 1 | OTP targeting is active |
| bp_code | output | 4 | Current block-protect code |
| sec_status | output | 2 | Bit 1 is the customer lock, bit 0 is the factory lock |

## Verification
Within one cycle, the grant decision reads the write-enable latch and the same command clears that latch, so both happen at the same clock edge. The bench provokes this in two ways. It issues commands back to back with and without a preceding write enable. It also follows a granted write with a second write that has no new enable, which must be denied.

The same pattern covers a protect write or a lock write immediately followed by a dependent program. The first write commits at an edge, and the program's decision in the next cycle must already use the new value. The bench judges each response in the cycle after its command against a protection map and a lock map that it computes arithmetically.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int BP_W = 4;

  typedef enum logic [2:0] {
    OP_WREN      = 3'd0,
    OP_PROG      = 3'd1,
    OP_BERASE    = 3'd2,
    OP_OTP_ENTER = 3'd3,
    OP_OTP_EXIT  = 3'd4,
    OP_SEC_WR    = 3'd5,
    OP_BP_WR     = 3'd6,
    OP_CERASE    = 3'd7
  } fpc_op_e;
endpackage

// File: rtl/fpc_rst_sync.sv
module fpc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/fpc_prot_map.sv
module fpc_prot_map #(
  parameter int BLK_W = 5,
  parameter int BP_W  = 4
) (
  input  logic [BP_W-1:0]  code,
  input  logic [BLK_W-1:0] blk,
  output logic             blk_prot,
  output logic             any_prot
);
  localparam int NBLK     = 1 << BLK_W;
  localparam int ALL_CODE = (1 << BP_W) - 1;
  localparam int BOT_LO   = ALL_CODE - BLK_W;

  int c;
  int bidx;
  int span;

  always_comb begin
    c        = int'(code);
    bidx     = int'(blk);
    span     = 0;
    blk_prot = 1'b1;
    if (c == 0) begin
      blk_prot = 1'b0;
    end else if (c <= BLK_W) begin
      // top-down region doubling per step
      span     = 1 << (c - 1);
      blk_prot = bidx >= (NBLK - span);
    end else if (c >= BOT_LO && c < ALL_CODE) begin
      // bottom-up region leaving a shrinking unguarded top
      span     = 1 << (ALL_CODE - 1 - c);
      blk_prot = bidx < (NBLK - span);
    end
  end

  assign any_prot = (code != '0);
endmodule

// File: rtl/fpc_otp_guard.sv
module fpc_otp_guard #(
  parameter int OFS_W     = 6,
  parameter int FACT_SPAN = 16
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic             fact_lock,
  input  logic             cust_lock,
  output logic             locked
);
  logic in_fact;

  assign in_fact = int'(ofs) < FACT_SPAN;
  assign locked  = in_fact ? fact_lock : cust_lock;
endmodule

// File: rtl/fpc_access_ctrl.sv
module fpc_access_ctrl
  import fpc_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 8,
  parameter int BLK_W     = 5,
  parameter int BLK_LSB   = 16,
  parameter int OTP_OFS_W = 6,
  parameter int FACT_SPAN = 16,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              factory_lock,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              resp_valid,
  output logic              resp_grant,
  output logic              resp_otp,
  output logic              wel,
  output logic              otp_mode,
  output logic [BP_W-1:0]   bp_code,
  output logic [1:0]        sec_status
);
  localparam int BLK_MSB = BLK_LSB + BLK_W - 1;

  logic wrst_s_n, por_s_n;
  logic warm_n;
  assign warm_n = rst_n & por_n;

  fpc_rst_sync #(.STAGES(SYNC_STG)) u_sync_warm (.clk(clk), .arst_n(warm_n), .srst_n(wrst_s_n));
  fpc_rst_sync #(.STAGES(SYNC_STG)) u_sync_por  (.clk(clk), .arst_n(por_n),  .srst_n(por_s_n));

  // state
  logic            wel_q, wel_d;
  logic            otp_q, otp_d;
  logic [BP_W-1:0] bp_q, bp_d;
  logic            bp_en;
  logic            cust_q, cust_d;
  logic            cust_en;
  logic            rv_q, rv_d, rg_q, rg_d, ro_q, ro_d;

  // decode
  fpc_op_e op;
  logic is_prog, is_berase, is_cerase, is_access, is_write;
  logic is_wren, is_enter, is_exit, is_sec, is_bp;
  logic blk_prot, any_prot, otp_locked, allow;

  assign op        = fpc_op_e'(cmd_op);
  assign is_wren   = cmd_valid && (op == OP_WREN);
  assign is_prog   = cmd_valid && (op == OP_PROG);
  assign is_berase = cmd_valid && (op == OP_BERASE);
  assign is_cerase = cmd_valid && (op == OP_CERASE);
  assign is_enter  = cmd_valid && (op == OP_OTP_ENTER);
  assign is_exit   = cmd_valid && (op == OP_OTP_EXIT);
  assign is_sec    = cmd_valid && (op == OP_SEC_WR);
  assign is_bp     = cmd_valid && (op == OP_BP_WR);
  assign is_access = is_prog | is_berase | is_cerase;
  assign is_write  = is_access | is_sec | is_bp;

  fpc_prot_map #(.BLK_W(BLK_W), .BP_W(BP_W)) u_map (
    .code(bp_q), .blk(cmd_addr[BLK_MSB:BLK_LSB]),
    .blk_prot(blk_prot), .any_prot(any_prot)
  );

  fpc_otp_guard #(.OFS_W(OTP_OFS_W), .FACT_SPAN(FACT_SPAN)) u_guard (
    .ofs(cmd_addr[OTP_OFS_W-1:0]), .fact_lock(factory_lock),
    .cust_lock(cust_q), .locked(otp_locked)
  );

  logic unused_bits;
  assign unused_bits = ^{cmd_addr[ADDR_W-1:BLK_MSB+1], cmd_addr[BLK_LSB-1:OTP_OFS_W],
                         cmd_data[DATA_W-1:BP_W]};

  // next state
  always_comb begin
    if (otp_q) allow = is_prog && !otp_locked;
    else if (is_cerase) allow = !any_prot;
    else allow = (is_prog || is_berase) && !blk_prot;

    wel_d = wel_q;
    if (is_wren)  wel_d = 1'b1;
    if (is_write) wel_d = 1'b0;

    otp_d = otp_q;
    if (is_enter) otp_d = 1'b1;
    if (is_exit)  otp_d = 1'b0;

    bp_en   = is_bp && wel_q;
    bp_d    = cmd_data[BP_W-1:0];
    cust_en = is_sec && wel_q && cmd_data[1];
    cust_d  = 1'b1;

    rv_d = is_access;
    rg_d = is_access && wel_q && allow;
    ro_d = is_access && otp_q;
  end

  // registers: warm domain
  always_ff @(posedge clk or negedge wrst_s_n) begin
    if (!wrst_s_n) begin
      wel_q <= 1'b0;
      otp_q <= 1'b0;
      rv_q  <= 1'b0;
      rg_q  <= 1'b0;
      ro_q  <= 1'b0;
    end else begin
      wel_q <= wel_d;
      otp_q <= otp_d;
      rv_q  <= rv_d;
      rg_q  <= rg_d;
      ro_q  <= ro_d;
    end
  end

  // registers: persistent domain
  always_ff @(posedge clk or negedge por_s_n) begin
    if (!por_s_n) begin
      bp_q   <= '0;
      cust_q <= 1'b0;
    end else begin
      if (bp_en)   bp_q   <= bp_d;
      if (cust_en) cust_q <= cust_d;
    end
  end

  assign resp_valid = rv_q;
  assign resp_grant = rg_q;
  assign resp_otp   = ro_q;
  assign wel        = wel_q;
  assign otp_mode   = otp_q;
  assign bp_code    = bp_q;
  assign sec_status = {cust_q, factory_lock};

  // R2
  wel_consumed_chk: assert property (@(posedge clk) disable iff (!wrst_s_n)
    is_write |=> !wel);
  // R2
  grant_needs_wel_chk: assert property (@(posedge clk) disable iff (!wrst_s_n)
    is_access && !wel |=> !resp_grant);
  // R9
  cust_lock_sticky_chk: assert property (@(posedge clk) disable iff (!por_s_n)
    sec_status[1] |=> sec_status[1]);
  // R7
  otp_erase_deny_chk: assert property (@(posedge clk) disable iff (!wrst_s_n)
    (is_berase || is_cerase) && otp_mode |=> resp_valid && !resp_grant && resp_otp);
  // R11
  resp_single_chk: assert property (@(posedge clk) disable iff (!wrst_s_n)
    resp_valid && !$past(is_access) |-> 1'b0);
  // R10
  bp_hold_chk: assert property (@(posedge clk) disable iff (!por_s_n)
    !(is_bp && wel) |=> $stable(bp_code));
endmodule

// File: tb/test_fpc_access_ctrl.sv
module test_fpc_access_ctrl;
  logic clk = 1'b0;
  logic rst_n, por_n, factory_lock, cmd_valid;
  logic [2:0] cmd_op;
  logic [23:0] cmd_addr;
  logic [7:0] cmd_data;
  logic resp_valid, resp_grant, resp_otp, wel, otp_mode;
  logic [3:0] bp_code;
  logic [1:0] sec_status;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fpc_access_ctrl i_fpc_access_ctrl (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .factory_lock(factory_lock),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .resp_valid(resp_valid), .resp_grant(resp_grant), .resp_otp(resp_otp),
    .wel(wel), .otp_mode(otp_mode), .bp_code(bp_code), .sec_status(sec_status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // drive at falling edge, result visible at next falling edge
  task automatic issue(input int op, input logic [23:0] addr, input logic [7:0] data);
    cmd_valid = 1'b1;
    cmd_op    = 3'(op);
    cmd_addr  = addr;
    cmd_data  = data;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic bit exp_prot(input int code, input int blk);
    case (code)
      0:  return 1'b0;
      1:  return blk >= 31;
      2:  return blk >= 30;
      3:  return blk >= 28;
      4:  return blk >= 24;
      5:  return blk >= 16;
      10: return blk < 16;
      11: return blk < 24;
      12: return blk < 28;
      13: return blk < 30;
      14: return blk < 31;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string prot_req(input int code);
    if (code >= 1 && code <= 5) return "R3";
    if (code >= 10 && code <= 14) return "R4";
    return "R5";
  endfunction

  task automatic set_bp(input int code);
    issue(0, 24'h0, 8'h0);
    issue(6, 24'h0, 8'(code));
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; por_n = 0; factory_lock = 1; cmd_valid = 0;
    cmd_op = 0; cmd_addr = 0; cmd_data = 0;
    idle(3);
    rst_n = 1; por_n = 1;
    idle(4);
    // R1 reset state
    chk("R1 wel", wel, 0);
    chk("R1 otp_mode", otp_mode, 0);
    chk("R1 resp_valid", resp_valid, 0);
    chk("R1 bp_code", bp_code, 0);
    chk("R1 sec_status", sec_status, 2'b01);

    // R2 without enable
    issue(1, 24'h000100, 0);
    chk("R11 resp_valid", resp_valid, 1);
    chk("R2 deny no wel", resp_grant, 0);
    idle(1);
    chk("R11 one pulse", resp_valid, 0);
    issue(0, 0, 0);
    chk("R2 wel set", wel, 1);
    chk("R11 no resp wren", resp_valid, 0);
    issue(1, 24'h000100, 0);
    chk("R2 grant with wel", resp_grant, 1);
    chk("R2 wel cleared", wel, 0);
    issue(1, 24'h000100, 0);
    chk("R2 back-to-back deny", resp_grant, 0);

    // R3 R4 R5 R6 sweep
    for (int code = 0; code < 16; code++) begin
      set_bp(code);
      chk("R10 bp load", bp_code, code);
      chk("R2 wel cleared by bp write", wel, 0);
      chk("R11 no resp bp write", resp_valid, 0);
      for (int blk = 0; blk < 32; blk++) begin
        issue(0, 0, 0);
        issue(2, {3'(blk * 3), 5'(blk), 16'h4321}, 0);
        chk({prot_req(code), " R6 berase"}, resp_grant, !exp_prot(code, blk));
        chk("R7 array target", resp_otp, 0);
        issue(0, 0, 0);
        issue(1, {3'b111, 5'(blk), 16'h00ff}, 0);
        chk({prot_req(code), " R6 prog"}, resp_grant, !exp_prot(code, blk));
      end
      issue(0, 0, 0);
      issue(7, 0, 0);
      chk("R6 chip erase", resp_grant, code == 0);
    end

    // R10 protect write without enable ignored
    set_bp(3);
    issue(6, 0, 8'h0a);
    chk("R10 ignored", bp_code, 3);

    // R7 R8 OTP mode, factory locked, customer open
    set_bp(15);
    issue(3, 0, 0);
    chk("R7 enter", otp_mode, 1);
    chk("R11 no resp enter", resp_valid, 0);
    for (int ofs = 0; ofs < 64; ofs++) begin
      issue(0, 0, 0);
      issue(1, {18'h3ffc0 + 18'(ofs), 6'(ofs)}, 0);
      chk("R8 otp factory-locked map", resp_grant, ofs >= 16);
      chk("R7 otp target", resp_otp, 1);
    end
    issue(0, 0, 0);
    issue(2, 24'h000000, 0);
    chk("R7 erase in otp", resp_grant, 0);
    issue(0, 0, 0);
    chk("R1 wel before warm reset", wel, 1);

    // R1 warm reset keeps persistent state
    rst_n = 0;
    idle(2);
    rst_n = 1;
    idle(4);
    chk("R1 warm otp", otp_mode, 0);
    chk("R1 warm wel", wel, 0);
    chk("R1 warm bp kept", bp_code, 15);

    // R9 security register
    issue(5, 0, 8'h02);
    chk("R9 no wel no set", sec_status[1], 0);
    issue(0, 0, 0);
    issue(5, 0, 8'hfd);
    chk("R9 bit0 ignored", sec_status, 2'b01);
    chk("R11 no resp sec", resp_valid, 0);
    issue(0, 0, 0);
    issue(5, 0, 8'h02);
    chk("R9 lock set", sec_status[1], 1);
    issue(0, 0, 0);
    issue(5, 0, 8'h00);
    chk("R9 lock sticky", sec_status[1], 1);
    factory_lock = 0;
    set_bp(0);
    issue(3, 0, 0);
    for (int ofs = 0; ofs < 64; ofs++) begin
      issue(0, 0, 0);
      issue(1, {18'h0, 6'(ofs)}, 0);
      chk("R8 otp customer-locked map", resp_grant, ofs < 16);
    end
    chk("R9 factory mirror", sec_status[0], 0);
    issue(4, 0, 0);
    chk("R7 exit", otp_mode, 0);
    issue(0, 0, 0);
    issue(1, 24'h1f0000, 0);
    chk("R7 back to array", resp_otp, 0);

    // R1 power-on reset clears persistent state
    set_bp(9);
    rst_n = 1;
    por_n = 0;
    idle(2);
    por_n = 1;
    idle(4);
    chk("R1 por bp", bp_code, 0);
    chk("R1 por lock", sec_status[1], 0);

    done = 1;
    summary();
    $finish;
  end
endmodule